// File: doc/BRIEF.md
# Carrying Subtract Execution Unit

This block is one integer execution slot for the "subtract from, carrying" operation. Each cycle it takes a 32-bit instruction word, the two source operand values already read from the register file, and the current summary-overflow state. It decodes the word, forms the difference as the second source minus the first, and registers the destination index, the result, the carry, the overflow pair and a 4-bit condition field. Each of these has its own write strobe, so the surrounding pipeline can commit them to architectural state one cycle after issue.

The difference is built as the inverted first operand plus the second operand plus one. The carry out of that sum therefore means "no borrow": it is set when the second source is not below the first as unsigned numbers. Two flag bits in the instruction control the side effects. One enables overflow reporting, with a sticky summary bit that only ever accumulates. The other enables the condition-field update, a signed compare of the result against zero with the updated summary bit folded in. Signed overflow only changes status bits and never raises an exception. Source register indices are passed out combinationally as the register-file read addresses. A decode-valid output marks words that do not belong to this operation, and for those every strobe stays low.

Top module: `subc_exec_unit`

## Requirements
- R1: A word matches when bits [31:26] equal 31 and bits [9:1] equal 8 (the base word is 0x7C000010). `dec_ok` shows the match one clock after the word is applied.
- R2: The source indices come from bits [20:16] (first source) and [15:11] (second source) and reach `src_a_idx`/`src_b_idx` in the same cycle. The destination index comes from bits [25:21] and is registered onto `dst_idx`. The overflow-enable flag is bit [10] and the record flag is bit [0].
- R3: One clock after a matching word, `dst_data` equals `opnd_b - opnd_a` modulo 2^32.
- R4: `carry_out` is 1 exactly when `opnd_b >= opnd_a` as unsigned numbers.
- R5: With overflow-enable set, `ovf_we` is 1 and `ovf_bit` is 1 when the true signed difference lies outside [-2^31, 2^31-1]. `sum_ovf_bit` is `sum_ovf_in` OR `ovf_bit`, so it is never cleared. With overflow-enable clear, `ovf_we` is 0.
- R6: With the record flag set, `cond_we` is 1 and `cond_field` = {LT, GT, EQ, SO}: bit 3 is LT, bit 2 is GT, bit 1 is EQ and bit 0 is SO. LT, GT and EQ come from a signed compare of the result against zero, and exactly one of the three is set. With the record flag clear, `cond_we` is 0.
- R7: `cond_field[0]` holds the summary overflow after this operation's update: `sum_ovf_in | overflow` when overflow-enable is set, and `sum_ovf_in` otherwise.
- R8: Equal operands (as when both sources name the same register) give result 0, carry 1 and, when recorded, EQ set.
- R9: For a word that does not match, `dec_ok`, `dst_we`, `carry_we`, `ovf_we` and `cond_we` are all 0 one clock later.
- R10: While reset is asserted, every registered output is 0.
- R11: `dst_we` and `carry_we` are 1 for every matching word, whatever the flag bits are.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_word | input | 32 | Instruction word at issue |
| opnd_a | input | 32 | First source value (subtrahend) |
| opnd_b | input | 32 | Second source value (minuend) |
| sum_ovf_in | input | 1 | Current summary-overflow state |
| src_a_idx | output | 5 | Register-file read index, first source |
| src_b_idx | output | 5 | Register-file read index, second source |
| dec_ok | output | 1 | Registered: the word matched this operation |
| dst_idx | output | 5 | Registered destination register index |
| dst_data | output | 32 | Registered difference |
| dst_we | output | 1 | Destination write strobe |
| carry_out | output | 1 | No-borrow carry |
| carry_we | output | 1 | Carry write strobe |
| ovf_bit | output | 1 | Signed-overflow bit |
| sum_ovf_bit | output | 1 | Updated sticky summary-overflow bit |
| ovf_we | output | 1 | Write strobe for the overflow pair |
| cond_field | output | 4 | {LT, GT, EQ, SO} condition field |
| cond_we | output | 1 | Condition-field write strobe |

## Verification
The bench crosses the boundary values 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF as both operands under all four flag combinations. A unit that reported a borrow instead of a carry, or computed A minus B, fails these pairs at once. So does one whose overflow test looks at the wrong signs, which misses 0x80000000 minus 1 and 0x7FFFFFFF minus 0xFFFFFFFF. A summary bit that is entered with a 1 and no fresh overflow is checked so that it stays set, and the condition field is checked to carry the updated value; a design that cleared the bit, or folded in the stale one, would show a wrong SO bit. Near-miss words (a wrong primary or extended opcode) must leave every strobe low, and a decoder that looks at only one of the two fields would write state for them.

// File: rtl/subc_pkg.sv
package subc_pkg;
   localparam int unsigned INSN_W    = 32;
   localparam int unsigned IDX_W     = 5;
   localparam int unsigned PRIM_HI   = 31;
   localparam int unsigned PRIM_LO   = 26;
   localparam int unsigned PRIM_VAL  = 31;
   localparam int unsigned EXT_HI    = 9;
   localparam int unsigned EXT_LO    = 1;
   localparam int unsigned EXT_VAL   = 8;
   localparam int unsigned DST_LO    = 21;
   localparam int unsigned SRCA_LO   = 16;
   localparam int unsigned SRCB_LO   = 11;
   localparam int unsigned OVEN_BIT  = 10;
   localparam int unsigned REC_BIT   = 0;
   localparam int unsigned PRIM_W    = PRIM_HI - PRIM_LO + 1;
   localparam int unsigned EXT_W     = EXT_HI - EXT_LO + 1;

   typedef struct packed {
      logic             match;
      logic [IDX_W-1:0] dst;
      logic [IDX_W-1:0] sa;
      logic [IDX_W-1:0] sb;
      logic             ovf_en;
      logic             rec;
   } dec_t;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cond_t;
endpackage

// File: rtl/subc_decode.sv
module subc_decode
   import subc_pkg::*;
(
   input  logic [INSN_W-1:0] word,
   output dec_t              dec
);
   logic [PRIM_W-1:0] prim;
   logic [EXT_W-1:0]  ext;

   assign prim = word[PRIM_HI:PRIM_LO];
   assign ext  = word[EXT_HI:EXT_LO];

   always_comb begin
      dec.match  = (prim == PRIM_W'(PRIM_VAL)) && (ext == EXT_W'(EXT_VAL));
      dec.dst    = word[DST_LO  +: IDX_W];
      dec.sa     = word[SRCA_LO +: IDX_W];
      dec.sb     = word[SRCB_LO +: IDX_W];
      dec.ovf_en = word[OVEN_BIT];
      dec.rec    = word[REC_BIT];
   end
endmodule

// File: rtl/subc_adder.sv
module subc_adder #(
   parameter int unsigned W     = 32,
   parameter int unsigned STYLE = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] diff,
   output logic         cout,
   output logic         ovf
);
   localparam int unsigned MSB = W - 1;

   logic [W-1:0] na;
   assign na = ~a;

   generate
      if (STYLE == 0) begin : g_flat
         logic [W:0] wide;
         assign wide = {1'b0, na} + {1'b0, b} + {{W{1'b0}}, 1'b1};
         assign diff = wide[W-1:0];
         assign cout = wide[W];
         assign ovf  = (na[MSB] == b[MSB]) && (wide[MSB] != b[MSB]);
      end else if (STYLE == 1) begin : g_ripple
         logic [W:0] c;
         assign c[0] = 1'b1;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign diff[i]  = na[i] ^ b[i] ^ c[i];
            assign c[i+1]   = (na[i] & b[i]) | (c[i] & (na[i] ^ b[i]));
         end
         assign cout = c[W];
         assign ovf  = c[W] ^ c[W-1];
      end else begin : g_bad
         $error("subc_adder: STYLE must be 0 or 1");
      end
   endgenerate
endmodule

// File: rtl/subc_flags.sv
module subc_flags
   import subc_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] diff,
   input  logic         ovf,
   input  logic         ovf_en,
   input  logic         so_in,
   output cond_t        cond,
   output logic         so_new
);
   logic neg, zero;

   assign neg    = diff[W-1];
   assign zero   = (diff == '0);
   assign so_new = so_in | (ovf_en & ovf);

   always_comb begin
      cond.lt = neg;
      cond.eq = zero;
      cond.gt = !neg && !zero;
      cond.so = so_new;
   end
endmodule

// File: rtl/subc_exec_unit.sv
module subc_exec_unit
   import subc_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDER_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       instr_word,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              sum_ovf_in,
   output logic [4:0]        src_a_idx,
   output logic [4:0]        src_b_idx,
   output logic              dec_ok,
   output logic [4:0]        dst_idx,
   output logic [DATA_W-1:0] dst_data,
   output logic              dst_we,
   output logic              carry_out,
   output logic              carry_we,
   output logic              ovf_bit,
   output logic              sum_ovf_bit,
   output logic              ovf_we,
   output logic [3:0]        cond_field,
   output logic              cond_we
);
   generate
      if (DATA_W < 2) begin : g_chk_w
         $error("subc_exec_unit: DATA_W must be at least 2");
      end
      if (ADDER_STYLE > 1) begin : g_chk_s
         $error("subc_exec_unit: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   dec_t              dec;
   logic [DATA_W-1:0] diff;
   logic              cy, ov, so_nx;
   cond_t             cnd;

   subc_decode u_dec (
      .word (instr_word),
      .dec  (dec)
   );

   subc_adder #(.W(DATA_W), .STYLE(ADDER_STYLE)) u_add (
      .a    (opnd_a),
      .b    (opnd_b),
      .diff (diff),
      .cout (cy),
      .ovf  (ov)
   );

   subc_flags #(.W(DATA_W)) u_flg (
      .diff   (diff),
      .ovf    (ov),
      .ovf_en (dec.ovf_en),
      .so_in  (sum_ovf_in),
      .cond   (cnd),
      .so_new (so_nx)
   );

   assign src_a_idx = dec.sa;
   assign src_b_idx = dec.sb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_ok      <= 1'b0;
         dst_idx     <= '0;
         dst_data    <= '0;
         dst_we      <= 1'b0;
         carry_out   <= 1'b0;
         carry_we    <= 1'b0;
         ovf_bit     <= 1'b0;
         sum_ovf_bit <= 1'b0;
         ovf_we      <= 1'b0;
         cond_field  <= '0;
         cond_we     <= 1'b0;
      end else begin
         dec_ok      <= dec.match;
         dst_idx     <= dec.dst;
         dst_data    <= diff;
         dst_we      <= dec.match;
         carry_out   <= cy;
         carry_we    <= dec.match;
         ovf_bit     <= dec.ovf_en & ov;
         sum_ovf_bit <= so_nx;
         ovf_we      <= dec.match & dec.ovf_en;
         cond_field  <= cnd;
         cond_we     <= dec.match & dec.rec;
      end
   end
endmodule

// File: rtl/subc_exec_chk.sv
module subc_exec_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic              sum_ovf_in,
   input logic              dec_ok,
   input logic [DATA_W-1:0] dst_data,
   input logic              dst_we,
   input logic              carry_out,
   input logic              carry_we,
   input logic              ovf_bit,
   input logic              sum_ovf_bit,
   input logic              ovf_we,
   input logic [3:0]        cond_field,
   input logic              cond_we
);
   // R3
   result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_we |-> dst_data == DATA_W'($past(opnd_b) - $past(opnd_a)));

   // R4
   carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      carry_we |-> carry_out == ($past(opnd_b) >= $past(opnd_a)));

   // R5
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_we |-> sum_ovf_bit == ($past(sum_ovf_in) | ovf_bit));

   // R6
   cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond_we |-> $countones(cond_field[3:1]) == 1);

   // R7
   cond_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond_we |-> cond_field[0] == (ovf_we ? sum_ovf_bit : $past(sum_ovf_in)));

   // R9
   no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_ok |-> !(dst_we || carry_we || ovf_we || cond_we));

   // R11
   strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_ok |-> dst_we && carry_we);
endmodule

bind subc_exec_unit subc_exec_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/subc_exec_unit_test.sv
`timescale 1ns/1ps
module subc_exec_unit_test;
   typedef struct {
      logic        dec;
      logic [4:0]  dst;
      logic [31:0] data;
      logic        ca;
      logic        ovwe;
      logic        ov;
      logic        so;
      logic        cwe;
      logic [3:0]  cond;
      logic [31:0] word;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr_word = 32'h0;
   logic [31:0] opnd_a = 32'h0, opnd_b = 32'h0;
   logic        sum_ovf_in = 1'b0;
   logic [4:0]  src_a_idx, src_b_idx, dst_idx;
   logic        dec_ok, dst_we, carry_out, carry_we, ovf_bit, sum_ovf_bit, ovf_we, cond_we;
   logic [31:0] dst_data;
   logic [3:0]  cond_field;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   subc_exec_unit uut (.*);

   function automatic logic [31:0] mk_word(logic [4:0] d, logic [4:0] sa, logic [4:0] sb,
                                           logic oven, logic rec);
      return (32'd31 << 26) | (32'(d) << 21) | (32'(sa) << 16) | (32'(sb) << 11)
           | (32'(oven) << 10) | (32'd8 << 1) | 32'(rec);
   endfunction

   function automatic exp_t model(logic [31:0] w, logic [31:0] a, logic [31:0] b, logic so_in);
      exp_t e;
      longint t;
      logic [31:0] r;
      t       = longint'($signed(b)) - longint'($signed(a));
      r       = b - a;
      e.word  = w;
      e.dec   = (w[31:26] == 6'd31) && (w[9:1] == 9'd8);
      e.dst   = w[25:21];
      e.data  = r;
      e.ca    = (b >= a);
      e.ovwe  = e.dec && w[10];
      e.ov    = (t > 64'sd2147483647) || (t < -64'sd2147483648);
      e.so    = w[10] ? (so_in | e.ov) : so_in;
      e.cwe   = e.dec && w[0];
      e.cond  = {$signed(r) < 0, $signed(r) > 0, r == 32'd0, e.so};
      return e;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(logic [31:0] w, logic [31:0] a, logic [31:0] b, logic so_in);
      @(negedge clk);
      instr_word = w;
      opnd_a     = a;
      opnd_b     = b;
      sum_ovf_in = so_in;
      sb_q.push_back(model(w, a, b, so_in));
   endtask

   // monitor: outputs registered at the posedge after the negedge drive
   always begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(dec_ok == e.dec, "R1 dec_ok", 32'(dec_ok), 32'(e.dec));
         check(dst_we == e.dec && carry_we == e.dec, "R11/R9 dst_we,carry_we",
               {dst_we, carry_we}, {e.dec, e.dec});
         check(ovf_we == e.ovwe, "R5/R9 ovf_we", 32'(ovf_we), 32'(e.ovwe));
         check(cond_we == e.cwe, "R6/R9 cond_we", 32'(cond_we), 32'(e.cwe));
         if (e.dec) begin
            check(dst_idx == e.dst, "R2 dst_idx", 32'(dst_idx), 32'(e.dst));
            check(dst_data == e.data, "R3 dst_data", dst_data, e.data);
            check(carry_out == e.ca, "R4 carry_out", 32'(carry_out), 32'(e.ca));
            if (e.ovwe) begin
               check(ovf_bit == e.ov, "R5 ovf_bit", 32'(ovf_bit), 32'(e.ov));
               check(sum_ovf_bit == e.so, "R5 sum_ovf_bit", 32'(sum_ovf_bit), 32'(e.so));
            end
            if (e.cwe) begin
               check(cond_field[3:1] == e.cond[3:1], "R6 cond LT/GT/EQ",
                     32'(cond_field), 32'(e.cond));
               check(cond_field[0] == e.cond[0], "R7 cond SO",
                     32'(cond_field), 32'(e.cond));
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] corners [4];
      corners[0] = 32'h0000_0000;
      corners[1] = 32'h7FFF_FFFF;
      corners[2] = 32'h8000_0000;
      corners[3] = 32'hFFFF_FFFF;

      // R10: reset state
      repeat (3) @(posedge clk);
      #1;
      check({dec_ok, dst_we, carry_we, ovf_we, cond_we} == 5'b0, "R10 strobes in reset",
            32'({dec_ok, dst_we, carry_we, ovf_we, cond_we}), 32'h0);
      check(dst_data == 32'h0 && cond_field == 4'h0 && carry_out == 1'b0,
            "R10 data in reset", dst_data, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: base word, plain case
      drive(32'h7C00_0010, 32'd5, 32'd9, 1'b0);
      // R2: combinational read indices
      @(negedge clk);
      instr_word = mk_word(5'd7, 5'd19, 5'd28, 1'b0, 1'b0);
      #1;
      check(src_a_idx == 5'd19, "R2 src_a_idx", 32'(src_a_idx), 32'd19);
      check(src_b_idx == 5'd28, "R2 src_b_idx", 32'(src_b_idx), 32'd28);
      sb_q.push_back(model(instr_word, opnd_a, opnd_b, sum_ovf_in));

      // R3 R4 R5 R6 R7: corner crossing under all four flag settings
      for (int f = 0; f < 4; f++)
         for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
               drive(mk_word(5'(i * 4 + j), 5'd1, 5'd2, f[1], f[0]),
                     corners[i], corners[j], 1'b0);

      // R5 R7: sticky summary bit entered set with no fresh overflow
      drive(mk_word(5'd3, 5'd1, 5'd2, 1'b1, 1'b1), 32'd1, 32'd2, 1'b1);
      drive(mk_word(5'd3, 5'd1, 5'd2, 1'b0, 1'b1), 32'd1, 32'd2, 1'b1);
      drive(mk_word(5'd3, 5'd1, 5'd2, 1'b0, 1'b1), 32'h8000_0000, 32'd1, 1'b0);

      // R8: aliased sources
      drive(mk_word(5'd3, 5'd3, 5'd3, 1'b1, 1'b1), 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0);
      drive(mk_word(5'd4, 5'd9, 5'd9, 1'b0, 1'b1), 32'h8000_0000, 32'h8000_0000, 1'b1);

      // R9: near-miss words
      drive(32'h7C00_0010 ^ 32'h0400_0000, 32'd1, 32'd2, 1'b0);
      drive(32'h7C00_0010 ^ 32'h0000_0002, 32'd1, 32'd2, 1'b0);
      drive(32'h7C00_0010 | 32'h0000_0200, 32'd1, 32'd2, 1'b0);
      drive(32'hFFFF_FFFF, 32'd1, 32'd2, 1'b1);

      // random sweep
      for (int k = 0; k < 300; k++) begin
         logic [31:0] w;
         w = mk_word(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom), 1'($urandom));
         if (k % 17 == 0) w = $urandom;
         drive(w, $urandom, $urandom, 1'($urandom));
      end

      @(negedge clk);
      instr_word = 32'h0;
      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule